// File: doc/BRIEF.md
# Double-Buffer Half Tracker

This block keeps the write pointer for a circular sample buffer that is split into two equal halves. It is used for continuous streaming input, where a producer writes samples while a consumer drains one half at a time. Each write strobe stores one sample at the current write address, and the pointer then advances. When the pointer leaves the lower half for the upper half, the lower half is reported ready. When it wraps from the end of the upper half back to address zero, the upper half is reported ready.

The consumer pulses an acknowledge after it has taken the ready half, and this clears the flag. If a half completes while the flag is still raised and no acknowledge arrives in that cycle, the previous half has been overwritten before it was read. A saturating overrun counter records each such event. A start pulse latches the buffer size, clears the pointer, the flag and the counter, and begins filling at the lower half.

The control core is a three-state machine:
- ST_IDLE: out of reset, before any start.
- ST_LOWER: filling the lower half.
- ST_UPPER: filling the upper half.

Its transitions are:
- GO: start taken from any state, always entering ST_LOWER.
- CROSS: ST_LOWER to ST_UPPER on the strobe that writes the last lower address.
- WRAP: ST_UPPER to ST_LOWER on the strobe that writes the last upper address.
- HOLD: any other cycle, with the state unchanged.

Top module: `dbuf_half_tracker`

## Requirements
- R1: Before the first start, write strobes and acknowledges have no effect: the write address stays 0 and the ready flag stays low.
- R2: In the cycle after an accepted write strobe, the write address is one higher than before, unless a wrap occurs (R3). In a cycle without a strobe or start, the address holds.
- R3: The size is taken at start as follows. Bit 0 is ignored. A value below 2 acts as 2. A value of 2^ADDR_W or more acts as 2^ADDR_W. The half boundary is size/2, and after the strobe that writes address size-1 the address returns to 0.
- R4: The strobe that writes the last address of a half completes that half. The last lower address is size/2-1 and the last upper address is size-1. In the next cycle half_rdy is 1 and rdy_half gives the completed half: 0 for the lower half, 1 for the upper half.
- R5: half_ack clears half_rdy in the next cycle. An acknowledge while half_rdy is low changes nothing. An acknowledge in the same cycle as a half completion leaves half_rdy set for the new half and does not count an overrun.
- R6: A half completion while half_rdy is high and half_ack is low increments ovr_cnt by one. The counter saturates at 2^OVR_W-1.
- R7: start, including a start during a run, sets the write address, half_rdy, rdy_half and ovr_cnt to 0 in the next cycle, latches the new size, and begins filling the lower half.
- R8: After reset, all outputs are 0 and the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a new run; latches buf_size |
| buf_size | input | ADDR_W+1 | Buffer size in samples |
| wr_stb | input | 1 | One sample written at wr_addr |
| half_ack | input | 1 | Consumer has taken the ready half |
| wr_addr | output | ADDR_W | Current write address |
| half_rdy | output | 1 | A completed half awaits the consumer |
| rdy_half | output | 1 | Index of the last completed half |
| ovr_cnt | output | OVR_W | Saturating overrun count |

## Verification
The bench builds the block with ADDR_W=4 and OVR_W=3. A 16-sample maximum buffer makes the size clamp, odd sizes and the minimum size of 2 reachable with short strobe runs. A 3-bit counter reaches saturation after seven unacknowledged halves, so its ceiling is hit and then held within a few dozen cycles. A behavioural model follows every clock, and it is compared with all four outputs each cycle.

// File: rtl/dbt_pkg.sv
package dbt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOWER = 2'd1,
        ST_UPPER = 2'd2
    } dbt_state_e;

    // completion event handed from the pointer machine to the ready logic
    typedef struct packed {
        logic fire;
        logic idx;
    } dbt_done_t;

endpackage

// File: rtl/dbt_size_cfg.sv
module dbt_size_cfg #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W:0]   size_in,
    output logic [ADDR_W-1:0] last_lo,
    output logic [ADDR_W-1:0] last_hi
);

    localparam int PAIR_W = ADDR_W - 1;

    logic              over;
    logic [PAIR_W-1:0] pairs;
    logic [ADDR_W-1:0] lo_n;
    logic [ADDR_W-1:0] hi_n;
    logic              unused_lsb;

    assign unused_lsb = size_in[0];        // odd sizes round down (R3)
    assign over       = size_in[ADDR_W];
    assign pairs      = size_in[ADDR_W-1:1];

    always_comb begin
        if (over) begin
            lo_n = {1'b0, {PAIR_W{1'b1}}};
            hi_n = '1;
        end else if (pairs == '0) begin
            lo_n = '0;
            hi_n = {{(ADDR_W-1){1'b0}}, 1'b1};
        end else begin
            lo_n = {1'b0, pairs} - 1'b1;
            hi_n = {pairs, 1'b0} - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_lo <= '0;
            last_hi <= {{(ADDR_W-1){1'b0}}, 1'b1};
        end else if (start) begin
            last_lo <= lo_n;
            last_hi <= hi_n;
        end
    end

    AST_HALF_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
        last_hi == {last_lo[ADDR_W-2:0], 1'b1}) else $error("half split");  // R3

endmodule

// File: rtl/dbt_ptr_fsm.sv
module dbt_ptr_fsm
    import dbt_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] last_lo,
    input  logic [ADDR_W-1:0] last_hi,
    output logic [ADDR_W-1:0] wr_addr,
    output dbt_done_t         done
);

    dbt_state_e        st, st_n;
    logic [ADDR_W-1:0] addr_n;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            wr_addr <= '0;
        end else begin
            st      <= st_n;
            wr_addr <= addr_n;
        end
    end

    // next state, next address and completion output
    always_comb begin
        st_n   = st;
        addr_n = wr_addr;
        done   = '0;
        if (start) begin
            st_n   = ST_LOWER;                       // GO
            addr_n = '0;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    st_n = ST_IDLE;                  // strobes ignored
                end
                ST_LOWER: begin
                    if (wr_stb) begin
                        addr_n = wr_addr + 1'b1;
                        if (wr_addr == last_lo) begin
                            st_n      = ST_UPPER;    // CROSS
                            done.fire = 1'b1;
                            done.idx  = 1'b0;
                        end
                    end
                end
                ST_UPPER: begin
                    if (wr_stb) begin
                        if (wr_addr == last_hi) begin
                            st_n      = ST_LOWER;    // WRAP
                            addr_n    = '0;
                            done.fire = 1'b1;
                            done.idx  = 1'b1;
                        end else begin
                            addr_n = wr_addr + 1'b1;
                        end
                    end
                end
                default: st_n = ST_IDLE;
            endcase
        end
    end

    AST_IDLE_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |-> (wr_addr == '0)) else $error("idle addr");  // R1
    AST_LOWER_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_LOWER) |-> (wr_addr <= last_lo)) else $error("lower range");  // R3
    AST_UPPER_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_UPPER) |-> (wr_addr > last_lo && wr_addr <= last_hi)) else $error("upper range");  // R3
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_stb && !start) |=> $stable(wr_addr)) else $error("addr hold");  // R2
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_IDLE && wr_stb && !start) |=>
        (wr_addr == $past(wr_addr) + 1'b1 || wr_addr == '0)) else $error("addr step");  // R2
    AST_START_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (wr_addr == '0 && st == ST_LOWER)) else $error("start zero");  // R7

endmodule

// File: rtl/dbt_ready_ctrl.sv
module dbt_ready_ctrl
    import dbt_pkg::*;
#(
    parameter int OVR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  dbt_done_t        done,
    input  logic             half_ack,
    output logic             half_rdy,
    output logic             rdy_half,
    output logic [OVR_W-1:0] ovr_cnt
);

    localparam logic [OVR_W-1:0] OVR_MAX = '1;

    logic lost;

    assign lost = done.fire && half_rdy && !half_ack;

    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            half_rdy <= 1'b0;
            rdy_half <= 1'b0;
        end else if (done.fire) begin
            half_rdy <= 1'b1;
            rdy_half <= done.idx;
        end else if (half_ack) begin
            half_rdy <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            ovr_cnt <= '0;
        end else if (lost && ovr_cnt != OVR_MAX) begin
            ovr_cnt <= ovr_cnt + 1'b1;
        end
    end

    AST_DONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (done.fire && !start) |=> (half_rdy && rdy_half == $past(done.idx))) else $error("done flag");  // R4
    AST_ACK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (half_ack && !done.fire) |=> !half_rdy) else $error("ack clear");  // R5
    AST_OVR_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> (ovr_cnt >= $past(ovr_cnt))) else $error("ovr drop");  // R6
    AST_OVR_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (lost && !start && ovr_cnt != OVR_MAX) |=> (ovr_cnt == $past(ovr_cnt) + 1'b1)) else $error("ovr count");  // R6

endmodule

// File: rtl/dbuf_half_tracker.sv
module dbuf_half_tracker
    import dbt_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int OVR_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W:0]   buf_size,
    input  logic              wr_stb,
    input  logic              half_ack,
    output logic [ADDR_W-1:0] wr_addr,
    output logic              half_rdy,
    output logic              rdy_half,
    output logic [OVR_W-1:0]  ovr_cnt
);

    logic [ADDR_W-1:0] last_lo;
    logic [ADDR_W-1:0] last_hi;
    dbt_done_t         done;

    dbt_size_cfg #(.ADDR_W(ADDR_W)) u_size (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .size_in (buf_size),
        .last_lo (last_lo),
        .last_hi (last_hi)
    );

    dbt_ptr_fsm #(.ADDR_W(ADDR_W)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .wr_stb  (wr_stb),
        .last_lo (last_lo),
        .last_hi (last_hi),
        .wr_addr (wr_addr),
        .done    (done)
    );

    dbt_ready_ctrl #(.OVR_W(OVR_W)) u_rdy (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .done     (done),
        .half_ack (half_ack),
        .half_rdy (half_rdy),
        .rdy_half (rdy_half),
        .ovr_cnt  (ovr_cnt)
    );

endmodule

// File: tb/sim_dbuf_half_tracker.sv
`timescale 1ns/1ps
module sim_dbuf_half_tracker;

    localparam int AW   = 4;
    localparam int OW   = 3;
    localparam int SMAX = 1 << AW;
    localparam int OMAX = (1 << OW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW:0]   buf_size = '0;
    logic          wr_stb = 1'b0;
    logic          half_ack = 1'b0;
    logic [AW-1:0] wr_addr;
    logic          half_rdy;
    logic          rdy_half;
    logic [OW-1:0] ovr_cnt;

    int n_chk = 0;
    int n_bad = 0;
    bit ended = 0;

    // behavioural reference
    bit m_run = 0;
    int m_size = 2, m_addr = 0, m_rdy = 0, m_idx = 0, m_ovr = 0;

    always #2 clk = ~clk;

    dbuf_half_tracker #(.ADDR_W(AW), .OVR_W(OW)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .buf_size(buf_size),
        .wr_stb(wr_stb), .half_ack(half_ack), .wr_addr(wr_addr),
        .half_rdy(half_rdy), .rdy_half(rdy_half), .ovr_cnt(ovr_cnt)
    );

    always @(posedge clk) begin
        int comp;
        int s;
        if (!rst_n) begin
            m_run = 0; m_size = 2; m_addr = 0; m_rdy = 0; m_idx = 0; m_ovr = 0;
        end else if (start) begin
            s = int'(buf_size);
            if (s > SMAX) s = SMAX;
            s = s - (s % 2);
            if (s < 2) s = 2;
            m_size = s; m_addr = 0; m_rdy = 0; m_idx = 0; m_ovr = 0; m_run = 1;
        end else begin
            comp = -1;
            if (m_run && wr_stb) begin
                m_addr = m_addr + 1;
                if (m_addr == m_size / 2) comp = 0;
                else if (m_addr == m_size) begin m_addr = 0; comp = 1; end
            end
            if (comp >= 0) begin
                if (m_rdy == 1 && !half_ack && m_ovr < OMAX) m_ovr = m_ovr + 1;
                m_rdy = 1; m_idx = comp;
            end else if (half_ack) begin
                m_rdy = 0;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !ended) begin
            chk(int'(wr_addr) == m_addr, "R2 model wr_addr", int'(wr_addr), m_addr);
            chk(int'(half_rdy) == m_rdy, "R5 model half_rdy", int'(half_rdy), m_rdy);
            chk(int'(rdy_half) == m_idx, "R4 model rdy_half", int'(rdy_half), m_idx);
            chk(int'(ovr_cnt) == m_ovr, "R6 model ovr_cnt", int'(ovr_cnt), m_ovr);
        end
    end

    task automatic cyc(input bit s, input bit a, input bit go);
        wr_stb = s; half_ack = a; start = go;
        @(negedge clk);
        wr_stb = 0; half_ack = 0; start = 0;
    endtask

    task automatic strobes(input int n);
        for (int i = 0; i < n; i++) cyc(1, 0, 0);
    endtask

    task automatic run_start(input int sz);
        buf_size = sz[AW:0];
        cyc(0, 0, 1);
    endtask

    task automatic finish_up();
        if (!ended) begin
            ended = 1;
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(4 * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(wr_addr == 0 && !half_rdy && !rdy_half && ovr_cnt == 0, "R8 reset outputs", int'(wr_addr), 0);

        // R1: no start yet
        strobes(5);
        cyc(0, 1, 0);
        chk(wr_addr == 0, "R1 addr idle", int'(wr_addr), 0);
        chk(!half_rdy, "R1 flag idle", int'(half_rdy), 0);

        // size 8
        run_start(8);
        chk(wr_addr == 0, "R7 start addr", int'(wr_addr), 0);
        strobes(3);
        chk(wr_addr == 3, "R2 step", int'(wr_addr), 3);
        cyc(0, 0, 0); cyc(0, 0, 0);
        chk(wr_addr == 3, "R2 hold", int'(wr_addr), 3);
        strobes(1);
        chk(half_rdy && rdy_half == 0 && wr_addr == 4, "R4 lower ready", int'(rdy_half), 0);
        cyc(0, 1, 0);
        chk(!half_rdy, "R5 ack clears", int'(half_rdy), 0);
        cyc(0, 1, 0);
        chk(!half_rdy && ovr_cnt == 0, "R5 idle ack", int'(ovr_cnt), 0);
        strobes(4);
        chk(wr_addr == 0, "R3 wrap", int'(wr_addr), 0);
        chk(half_rdy && rdy_half == 1, "R4 upper ready", int'(rdy_half), 1);
        strobes(4);
        chk(ovr_cnt == 1 && rdy_half == 0, "R6 overrun", int'(ovr_cnt), 1);
        strobes(40);
        chk(ovr_cnt == OMAX, "R6 saturate", int'(ovr_cnt), OMAX);

        // restart mid-run and ack coincident with completion
        strobes(2);
        run_start(8);
        chk(ovr_cnt == 0 && !half_rdy && wr_addr == 0, "R7 restart clears", int'(ovr_cnt), 0);
        strobes(4);
        strobes(3);
        cyc(1, 1, 0);
        chk(half_rdy && rdy_half == 1 && ovr_cnt == 0, "R5 ack with completion", int'(ovr_cnt), 0);

        // odd size 7 -> 6
        run_start(7);
        strobes(3);
        chk(half_rdy && rdy_half == 0 && wr_addr == 3, "R3 odd size half", int'(wr_addr), 3);
        cyc(0, 1, 0);
        strobes(3);
        chk(wr_addr == 0 && rdy_half == 1, "R3 odd size wrap", int'(wr_addr), 0);

        // size 0 -> 2
        run_start(0);
        strobes(1);
        chk(wr_addr == 1 && rdy_half == 0 && half_rdy, "R3 min size half", int'(wr_addr), 1);
        strobes(1);
        chk(wr_addr == 0 && rdy_half == 1 && ovr_cnt == 1, "R3 min size wrap", int'(wr_addr), 0);

        // size 31 -> 16
        run_start(31);
        strobes(7);
        chk(!half_rdy, "R3 clamp no early ready", int'(half_rdy), 0);
        strobes(1);
        chk(half_rdy && rdy_half == 0 && wr_addr == 8, "R3 clamp half", int'(wr_addr), 8);
        cyc(0, 1, 0);
        strobes(8);
        chk(wr_addr == 0 && rdy_half == 1 && ovr_cnt == 0, "R3 clamp wrap", int'(wr_addr), 0);

        repeat (3) @(negedge clk);
        finish_up();
    end

endmodule